// File: doc/BRIEF.md
# Machine State Register Update Unit

This block owns the 64-bit machine state register of a 64-bit processor core and is the only place where that register changes. Every cycle it applies at most one update. The update is either synchronous reset, interrupt entry, return from interrupt, a short or full move-to, or nothing. Each kind of update writes only the bit ranges that belong to it; all other bits keep their value. A move-from returns the whole register. A return from interrupt also redirects the fetch stream to the saved return address.

Each cycle a small decoder picks one named action: ACT_HOLD, ACT_RESET, ACT_IRQ, ACT_RETURN, ACT_MT_SHORT, ACT_MT_FULL or ACT_READ. The state-register process then commits the next value for that action on the rising edge. The actions are chosen as follows:

- Reset wins over everything.
- Interrupt entry (`irq_take`) wins over any operation strobe.
- An operation code outside the three defined ones gives ACT_HOLD.

The pipeline drives a one-cycle strobe carrying the operation code, the L field and the operands. The register value shows on `msr_o` one edge later. The current enable bit qualifies the decrementer-pending flag.

Top module: `msr_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the register with 64'h8000_0000_0000_0001: bit 63 (64-bit mode) and bit 0 (little-endian) set, all others clear. Bit 0 is the least significant bit throughout.
- R2: When `irq_take` is high at an edge, bits 63 and 0 are set. Bits 15 (interrupt enable), 14 (problem state), 5 (instruction relocation), 4 (data relocation) and 1 (recoverable) are cleared. All other bits hold.
- R3: Operation code 3'd1 (return) loads bits 63:31, 26:22 and 15:0 from `sav_msr`. Bits 30:27 and 21:16 hold.
- R4: While a return is presented, `redir_o` is 1 in the same cycle and `redir_addr_o` equals `sav_addr` with bits 1:0 forced to 0. For any other input, `redir_o` is 0.
- R5: Operation code 3'd2 (move-to) with `op_l`=1 writes only bits 15 and 1 from `op_src`.
- R6: Operation code 3'd2 with `op_l`=0 writes bits 63:61, 59:13 and 11:1 from `op_src`. Bits 60, 12 and 0 hold.
- R7: After a return or an `op_l`=0 move-to, if the new bit 14 is 1, then bits 15, 5 and 4 are 1, whatever their source value was.
- R8: Operation code 3'd3 (move-from) places all 64 bits of the current register on `rd_data_o` in the same cycle. At any other time `rd_data_o` is zero.
- R9: `dec_irq_o` equals register bit 15 AND bit 63 of `dec_val`.
- R10: With `irq_take` high, an operation strobe in the same cycle has no effect: no redirect, no read data, and the register takes only the R2 update.
- R11: Operation codes 3'd0 and 3'd4 to 3'd7 leave the register unchanged and raise no redirect.
- R12: An update becomes visible on `msr_o` after the next rising edge. Without a strobe, interrupt or reset, and for a move-from, the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_take | input | 1 | Interrupt entry this cycle |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 3 | Operation: 1 return, 2 move-to, 3 move-from |
| op_l | input | 1 | Move-to form: 1 short, 0 full |
| op_src | input | 64 | Move-to source operand |
| sav_addr | input | 64 | Saved return address |
| sav_msr | input | 64 | Saved register image for return |
| dec_val | input | 64 | Decrementer value |
| msr_o | output | 64 | Current register |
| rd_data_o | output | 64 | Move-from read data |
| redir_o | output | 1 | Fetch redirect strobe |
| redir_addr_o | output | 64 | Redirect target |
| dec_irq_o | output | 1 | Enabled decrementer interrupt pending |

## Verification
The assertions check on every cycle the properties that relate the register to its own previous value:
- interrupt entry forces its bits;
- the short move-to disturbs nothing but bits 15 and 1;
- the full move-to never touches bits 60, 12 and 0;
- return keeps the partial-function bits;
- the problem-state fixup holds after return and full move-to;
- invalid codes leave the register unchanged.

The reset value, the exact loaded values, the interrupt-over-strobe priority, redirect address alignment, move-from data and the decrementer flag are shown by the bench. It sweeps every operation code, both L values and both interrupt states across a set of operand patterns, and compares against a reference computed from bit masks.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int MSR_W = 64;

    localparam int B_SF = 63;
    localparam int B_HV = 60;
    localparam int B_EE = 15;
    localparam int B_PR = 14;
    localparam int B_ME = 12;
    localparam int B_IR = 5;
    localparam int B_DR = 4;
    localparam int B_RI = 1;
    localparam int B_LE = 0;

    typedef enum logic [2:0] {
        OPC_NONE      = 3'd0,
        OPC_RETURN    = 3'd1,
        OPC_MOVE_TO   = 3'd2,
        OPC_MOVE_FROM = 3'd3
    } msr_opc_e;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_RESET,
        ACT_IRQ,
        ACT_RETURN,
        ACT_MT_SHORT,
        ACT_MT_FULL,
        ACT_READ
    } msr_act_e;

    function automatic logic [MSR_W-1:0] span(input int hi, input int lo);
        logic [MSR_W-1:0] m;
        m = '0;
        for (int i = 0; i < MSR_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [MSR_W-1:0] bitm(input int b);
        return span(b, b);
    endfunction

    localparam logic [MSR_W-1:0] RST_VAL    = bitm(B_SF) | bitm(B_LE);
    localparam logic [MSR_W-1:0] IRQ_SET    = bitm(B_SF) | bitm(B_LE);
    localparam logic [MSR_W-1:0] IRQ_CLR    = bitm(B_EE) | bitm(B_PR) | bitm(B_IR)
                                            | bitm(B_DR) | bitm(B_RI);
    localparam logic [MSR_W-1:0] RET_MASK   = span(63, 31) | span(26, 22) | span(15, 0);
    localparam logic [MSR_W-1:0] FULL_MASK  = span(63, 61) | span(59, 13) | span(11, 1);
    localparam logic [MSR_W-1:0] SHORT_MASK = bitm(B_EE) | bitm(B_RI);
    localparam logic [MSR_W-1:0] PR_FORCE   = bitm(B_EE) | bitm(B_IR) | bitm(B_DR);

endpackage

// File: rtl/msr_field_merge.sv
module msr_field_merge #(
    parameter int W = 64
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] src,
    input  logic [W-1:0] mask,
    output logic [W-1:0] merged
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign merged[i] = mask[i] ? src[i] : cur[i];
    end
endmodule

// File: rtl/msr_pr_fixup.sv
module msr_pr_fixup #(
    parameter int W      = 64,
    parameter int PR_BIT = 14,
    parameter logic [W-1:0] FORCE = '0
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_comb begin
        dout = din;
        if (din[PR_BIT]) dout = din | FORCE;
    end
endmodule

// File: rtl/msr_action_dec.sv
module msr_action_dec
    import msr_pkg::*;
(
    input  logic     rst,
    input  logic     irq_take,
    input  logic     op_valid,
    input  logic [2:0] op_code,
    input  logic     op_l,
    output msr_act_e act
);
    msr_opc_e opc;
    assign opc = msr_opc_e'(op_code);

    always_comb begin
        act = ACT_HOLD;
        if (rst) begin
            act = ACT_RESET;
        end else if (irq_take) begin
            act = ACT_IRQ;
        end else if (op_valid) begin
            unique case (opc)
                OPC_RETURN:    act = ACT_RETURN;
                OPC_MOVE_TO:   act = op_l ? ACT_MT_SHORT : ACT_MT_FULL;
                OPC_MOVE_FROM: act = ACT_READ;
                default:       act = ACT_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/msr_unit.sv
module msr_unit
    import msr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_take,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              op_l,
    input  logic [MSR_W-1:0]  op_src,
    input  logic [MSR_W-1:0]  sav_addr,
    input  logic [MSR_W-1:0]  sav_msr,
    input  logic [MSR_W-1:0]  dec_val,
    output logic [MSR_W-1:0]  msr_o,
    output logic [MSR_W-1:0]  rd_data_o,
    output logic              redir_o,
    output logic [MSR_W-1:0]  redir_addr_o,
    output logic              dec_irq_o
);
    msr_act_e          act;
    logic [MSR_W-1:0]  msr_q, msr_d;
    logic [MSR_W-1:0]  irq_nxt, ret_raw, ret_nxt, full_raw, full_nxt, short_nxt;

    msr_action_dec u_dec (
        .rst      (rst),
        .irq_take (irq_take),
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_l     (op_l),
        .act      (act)
    );

    msr_field_merge #(.W(MSR_W)) u_m_irq (
        .cur(msr_q), .src(IRQ_SET), .mask(IRQ_SET | IRQ_CLR), .merged(irq_nxt));
    msr_field_merge #(.W(MSR_W)) u_m_ret (
        .cur(msr_q), .src(sav_msr), .mask(RET_MASK), .merged(ret_raw));
    msr_field_merge #(.W(MSR_W)) u_m_full (
        .cur(msr_q), .src(op_src), .mask(FULL_MASK), .merged(full_raw));
    msr_field_merge #(.W(MSR_W)) u_m_short (
        .cur(msr_q), .src(op_src), .mask(SHORT_MASK), .merged(short_nxt));

    msr_pr_fixup #(.W(MSR_W), .PR_BIT(B_PR), .FORCE(PR_FORCE)) u_fx_ret (
        .din(ret_raw), .dout(ret_nxt));
    msr_pr_fixup #(.W(MSR_W), .PR_BIT(B_PR), .FORCE(PR_FORCE)) u_fx_full (
        .din(full_raw), .dout(full_nxt));

    // next-value selection per action
    always_comb begin
        unique case (act)
            ACT_RESET:    msr_d = RST_VAL;
            ACT_IRQ:      msr_d = irq_nxt;
            ACT_RETURN:   msr_d = ret_nxt;
            ACT_MT_SHORT: msr_d = short_nxt;
            ACT_MT_FULL:  msr_d = full_nxt;
            default:      msr_d = msr_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        msr_q <= msr_d;
    end

    // outputs
    always_comb begin
        msr_o        = msr_q;
        redir_o      = (act == ACT_RETURN);
        redir_addr_o = {sav_addr[MSR_W-1:2], 2'b00};
        rd_data_o    = (act == ACT_READ) ? msr_q : '0;
        dec_irq_o    = msr_q[B_EE] & dec_val[MSR_W-1];
    end

    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> (msr_q[B_SF] && msr_q[B_LE] && !msr_q[B_EE] && !msr_q[B_PR]
                      && !msr_q[B_IR] && !msr_q[B_DR] && !msr_q[B_RI])); // R2

    AST_SHORT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !irq_take && op_code == 3'd2 && op_l)
        |=> ((msr_q & ~SHORT_MASK) == ($past(msr_q) & ~SHORT_MASK))); // R5

    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !irq_take && op_code == 3'd2 && !op_l)
        |=> (msr_q[B_HV] == $past(msr_q[B_HV]) && msr_q[B_ME] == $past(msr_q[B_ME])
             && msr_q[B_LE] == $past(msr_q[B_LE]))); // R6

    AST_RET_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !irq_take && op_code == 3'd1)
        |=> (msr_q[30:27] == $past(msr_q[30:27]) && msr_q[21:16] == $past(msr_q[21:16]))); // R3

    AST_PR_FORCE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !irq_take && (op_code == 3'd1 || (op_code == 3'd2 && !op_l)))
        |=> (!msr_q[B_PR] || (msr_q[B_EE] && msr_q[B_IR] && msr_q[B_DR]))); // R7

    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!irq_take && (!op_valid || op_code == 3'd0 || op_code > 3'd3))
        |=> $stable(msr_q)); // R11
endmodule

// File: tb/sim_msr_unit.sv
`timescale 1ns/1ps
module sim_msr_unit;
    logic        clk = 1'b0;
    logic        rst, irq_take, op_valid, op_l;
    logic [2:0]  op_code;
    logic [63:0] op_src, sav_addr, sav_msr, dec_val;
    logic [63:0] msr_o, rd_data_o, redir_addr_o;
    logic        redir_o, dec_irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [63:0] model;

    always #5 clk = ~clk;

    msr_unit u0 (
        .clk(clk), .rst(rst), .irq_take(irq_take), .op_valid(op_valid),
        .op_code(op_code), .op_l(op_l), .op_src(op_src), .sav_addr(sav_addr),
        .sav_msr(sav_msr), .dec_val(dec_val), .msr_o(msr_o), .rd_data_o(rd_data_o),
        .redir_o(redir_o), .redir_addr_o(redir_addr_o), .dec_irq_o(dec_irq_o));

    function automatic logic [63:0] rng(input int hi, input int lo);
        logic [63:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] model_next(input logic [63:0] cur, input bit irq,
            input bit v, input int opc, input bit l,
            input logic [63:0] src, input logic [63:0] smsr);
        logic [63:0] m, r;
        r = cur;
        if (irq) begin
            r = r & ~(rng(15,14) | rng(5,4) | rng(1,1));
            r = r | rng(63,63) | rng(0,0);
        end else if (v && opc == 1) begin
            m = rng(63,31) | rng(26,22) | rng(15,0);
            r = (cur & ~m) | (smsr & m);
            if (r[14]) r = r | rng(15,15) | rng(5,4);
        end else if (v && opc == 2 && l) begin
            m = rng(15,15) | rng(1,1);
            r = (cur & ~m) | (src & m);
        end else if (v && opc == 2) begin
            m = rng(63,61) | rng(59,13) | rng(11,1);
            r = (cur & ~m) | (src & m);
            if (r[14]) r = r | rng(15,15) | rng(5,4);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        irq_take = 0; op_valid = 0; op_code = 0; op_l = 0;
    endtask

    initial begin
        logic [63:0] pats [8];
        logic [63:0] lf;
        string tg;
        pats[0] = '1;                       pats[1] = '0;
        pats[2] = 64'hAAAA_AAAA_AAAA_AAAA;  pats[3] = 64'h5555_5555_5555_5555;
        pats[4] = 64'h0000_0000_0000_4000;  pats[5] = 64'hFFFF_FFFF_FFFF_BFFF;
        pats[6] = 64'h1234_5678_9ABC_DEF3;  pats[7] = 64'hEDCB_A987_6543_7FFF;
        idle(); rst = 1; op_src = 0; sav_addr = 0; sav_msr = 0; dec_val = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        model = 64'h8000_0000_0000_0001;
        chk(msr_o == model, "R1 reset value", msr_o, model);
        chk(redir_o == 0 && rd_data_o == 0, "R1 outputs idle", {63'b0, redir_o}, 0);

        lf = 64'hACE1_2345_6789_0F0F;
        for (int p = 0; p < 8; p++) begin
            for (int opc = 0; opc < 8; opc++) begin
                for (int l = 0; l < 2; l++) begin
                    for (int irq = 0; irq < 2; irq++) begin
                        logic [63:0] exp, erd;
                        bit eredir;
                        lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
                        @(negedge clk);
                        op_valid = 1; op_code = 3'(opc); op_l = l[0]; irq_take = irq[0];
                        op_src = pats[p];
                        sav_msr = pats[(p + opc) % 8] ^ (lf & 64'h0000_0FFF_0000_0000);
                        sav_addr = lf;
                        #1;
                        eredir = (!irq && opc == 1);
                        erd = (!irq && opc == 3) ? model : 64'h0;
                        tg = irq ? "R10" : (opc == 1 ? "R4" : "R11");
                        chk(redir_o == eredir, {tg, " redirect"}, {63'b0, redir_o}, {63'b0, eredir});
                        if (eredir)
                            chk(redir_addr_o == {lf[63:2], 2'b00}, "R4 target", redir_addr_o,
                                {lf[63:2], 2'b00});
                        chk(rd_data_o == erd, irq ? "R10 read" : "R8 read", rd_data_o, erd);
                        exp = model_next(model, irq[0], 1'b1, opc, l[0], op_src, sav_msr);
                        @(posedge clk); #1;
                        if (irq) tg = (opc >= 1 && opc <= 3) ? "R10" : "R2";
                        else if (opc == 1) tg = "R3";
                        else if (opc == 2) tg = l ? "R5" : "R6";
                        else if (opc == 3) tg = "R12";
                        else tg = "R11";
                        chk(msr_o == exp, {tg, " register"}, msr_o, exp);
                        if (!irq && (opc == 1 || (opc == 2 && !l)) && exp[14])
                            chk(msr_o[15] && msr_o[5] && msr_o[4], "R7 problem-state force",
                                msr_o, exp);
                        model = exp;
                        @(negedge clk); idle();
                        @(posedge clk); #1;
                        chk(msr_o == model, "R12 hold idle", msr_o, model);
                    end
                end
            end
        end

        for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 4; d++) begin
                logic eflag;
                @(negedge clk);
                op_valid = 1; op_code = 3'd2; op_l = 1; op_src = e[0] ? 64'h8000 : 64'h0;
                @(negedge clk); idle();
                dec_val = {d[1], 31'h0, 30'h0, d[0], 1'b1};
                #1;
                eflag = e[0] & d[1];
                chk(dec_irq_o == eflag, "R9 decrementer flag", {63'b0, dec_irq_o},
                    {63'b0, eflag});
            end
        end

        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk(msr_o == 64'h8000_0000_0000_0001, "R1 reset again", msr_o,
            64'h8000_0000_0000_0001);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule